// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block watches bus writes that fall into the two boot-buffer address windows of a flash device and turns a handful of data codes into actions. One code asks the surrounding device for a warm reset. Another code arms a second-write state, and a following zero write asks an external page loader to fetch one full page (four 512-byte sectors) into data buffer 0. A third code fills the first three words of the boot buffer with identification bytes.

The block holds no page or block address of its own. It samples the current block and page addresses from the register file when a load starts. When the loader acknowledges, it hands back the page address, advanced by four and cut to eight bits, through a one-cycle update strobe. Each identification word is written through a narrow buffer write port, one word per cycle. While a load is outstanding or identification words are being written, further boot writes are dropped.

Top module: `bootcmd_ctrl`

## Requirements
- R1: Only writes to word offsets 0x0000 to 0x01FF and 0x8000 to 0x800F are decoded. A write to any other offset causes no action and leaves the armed state as it is.
- R2: An unarmed window write of 0x00F0 drives `core_rst_req` high for exactly the one cycle that follows the write.
- R3: An unarmed window write of 0x00E0 arms the block. The next accepted window write always disarms it, whatever its data.
- R4: An armed window write of 0x0000 drives `ld_req` high for exactly one cycle after the write. `ld_block` and `ld_page` carry `cur_block` and `cur_page` as they were at that write.
- R5: In the cycle after `ld_ack` is seen, `page_upd` is high for one cycle and `page_upd_val` equals (`ld_page` + 4) AND 0x00FF.
- R6: An armed window write of any non-zero value only disarms the block. It issues no load, and a 0x00F0 in that position issues no reset.
- R7: An unarmed window write of 0x0090 writes boot words 0, 1 and 2 on three consecutive cycles. The words carry the low bytes of `mfr_id`, `dev_id` and `wp_stat`, zero-extended to 16 bits.
- R8: An unarmed window write with any other data value causes no reset, no load, no buffer write and no arming.
- R9: While a load waits for its acknowledge, and while identification words are being written, window writes are ignored.
- R10: Reset (`rst_n` low) clears the armed state, and all output strobes are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 16 | Word offset of the write |
| bus_wdata | input | 16 | Write data |
| cur_block | input | 16 | Current block address register |
| cur_page | input | 16 | Current page address register |
| mfr_id | input | 16 | Manufacturer identifier |
| dev_id | input | 16 | Device identifier |
| wp_stat | input | 16 | Write-protection status |
| ld_req | output | 1 | One-cycle page load request |
| ld_block | output | 16 | Block address of the load |
| ld_page | output | 16 | Page address of the load |
| ld_ack | input | 1 | Loader completion acknowledge |
| page_upd | output | 1 | Page address update strobe |
| page_upd_val | output | 16 | New page address value |
| buf_we | output | 1 | Boot buffer word write enable |
| buf_idx | output | 2 | Boot buffer word index |
| buf_wdata | output | 16 | Boot buffer write data |
| core_rst_req | output | 1 | Warm reset request pulse |

## Verification
The armed flag has no output of its own. A wrong value shows up at the next window write. A stale arm turns a later zero write into a spurious `ld_req` one cycle after it. A lost arm suppresses a load that was due. A busy state that is stuck or released too early shows up as a dropped or an extra `core_rst_req` or `ld_req` on the first write after the load or identification sequence. A wrong word index shows up as misplaced identification bytes within three cycles of the 0x0090 write.

// File: rtl/bootcmd_pkg.sv
package bootcmd_pkg;

    parameter int DW = 16;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_RESET,
        OP_ARM,
        OP_IDREAD
    } boot_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_WAIT_ACK,
        ST_ID_WR
    } seq_state_e;

    localparam logic [DW-1:0] CODE_RESET  = 16'h00F0;
    localparam logic [DW-1:0] CODE_ARM    = 16'h00E0;
    localparam logic [DW-1:0] CODE_IDREAD = 16'h0090;

endpackage

// File: rtl/bootcmd_decode.sv
module bootcmd_decode
    import bootcmd_pkg::*;
#(
    parameter int              AW         = 16,
    parameter logic [AW-1:0]   MAIN_LAST  = 16'h01FF,
    parameter logic [AW-1:0]   SPARE_BASE = 16'h8000,
    parameter logic [AW-1:0]   SPARE_LAST = 16'h800F
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          hit,
    output boot_op_e      op,
    output logic          data_zero
);
    logic in_main;
    logic in_spare;

    always_comb begin
        in_main   = (addr <= MAIN_LAST);
        in_spare  = (addr >= SPARE_BASE) && (addr <= SPARE_LAST);
        hit       = wr_en && (in_main || in_spare);
        data_zero = (data == '0);
        unique case (data)
            CODE_RESET:  op = OP_RESET;
            CODE_ARM:    op = OP_ARM;
            CODE_IDREAD: op = OP_IDREAD;
            default:     op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/bootcmd_idwr.sv
module bootcmd_idwr
    import bootcmd_pkg::*;
#(
    parameter int NWORDS = 3,
    parameter int BW     = 8,
    localparam int IW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NWORDS-1:0][BW-1:0]   id_bytes,
    output logic                        buf_we,
    output logic [IW-1:0]               buf_idx,
    output logic [DW-1:0]               buf_wdata,
    output logic                        last
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NWORDS - 1);

    typedef struct packed {
        logic                      active;
        logic [IW-1:0]             idx;
        logic [NWORDS-1:0][BW-1:0] bytes;
    } idwr_t;

    idwr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
            st_d.bytes  = id_bytes;
        end else if (st_q.active) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.active = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_we    = st_q.active;
    assign buf_idx   = st_q.idx;
    assign buf_wdata = DW'(st_q.bytes[st_q.idx]);
    assign last      = st_q.active && (st_q.idx == LAST_IDX);

    // R7: words are written in ascending order on consecutive cycles
    a_r7_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && buf_idx != LAST_IDX) |=> (buf_we && buf_idx == $past(buf_idx) + 1'b1));

    // R7: the sequence stops after the last word
    a_r7_stops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && buf_idx == LAST_IDX && !$past(start)) |=> !buf_we || buf_idx == '0);

endmodule

// File: rtl/bootcmd_ctrl.sv
module bootcmd_ctrl
    import bootcmd_pkg::*;
#(
    parameter int AW        = 16,
    parameter int PAGE_W    = 8,
    parameter int PAGE_STEP = 4,
    parameter int ID_WORDS  = 3,
    parameter int ID_BW     = 8,
    localparam int IW       = $clog2(ID_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] cur_block,
    input  logic [DW-1:0] cur_page,
    input  logic [DW-1:0] mfr_id,
    input  logic [DW-1:0] dev_id,
    input  logic [DW-1:0] wp_stat,
    output logic          ld_req,
    output logic [DW-1:0] ld_block,
    output logic [DW-1:0] ld_page,
    input  logic          ld_ack,
    output logic          page_upd,
    output logic [DW-1:0] page_upd_val,
    output logic          buf_we,
    output logic [IW-1:0] buf_idx,
    output logic [DW-1:0] buf_wdata,
    output logic          core_rst_req
);
    typedef struct packed {
        seq_state_e    state;
        logic          ld_req;
        logic [DW-1:0] ld_block;
        logic [DW-1:0] ld_page;
        logic          page_upd;
        logic [DW-1:0] page_val;
        logic          rst_req;
    } ctrl_t;

    ctrl_t    ct_d, ct_q;
    logic     win_hit;
    boot_op_e win_op;
    logic     win_zero;
    logic     id_start;
    logic     id_last;
    logic [ID_WORDS-1:0][ID_BW-1:0] id_bytes;
    logic [PAGE_W-1:0] page_next;

    bootcmd_decode #(.AW(AW)) u_decode (
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .data      (bus_wdata),
        .hit       (win_hit),
        .op        (win_op),
        .data_zero (win_zero)
    );

    assign id_bytes[0] = mfr_id[ID_BW-1:0];
    assign id_bytes[1] = dev_id[ID_BW-1:0];
    assign id_bytes[2] = wp_stat[ID_BW-1:0];

    bootcmd_idwr #(.NWORDS(ID_WORDS), .BW(ID_BW)) u_idwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (id_start),
        .id_bytes  (id_bytes),
        .buf_we    (buf_we),
        .buf_idx   (buf_idx),
        .buf_wdata (buf_wdata),
        .last      (id_last)
    );

    assign page_next = ct_q.ld_page[PAGE_W-1:0] + PAGE_W'(PAGE_STEP);

    always_comb begin
        ct_d          = ct_q;
        ct_d.ld_req   = 1'b0;
        ct_d.page_upd = 1'b0;
        ct_d.rst_req  = 1'b0;
        id_start      = 1'b0;
        unique case (ct_q.state)
            ST_IDLE: begin
                if (win_hit) begin
                    unique case (win_op)
                        OP_RESET:  ct_d.rst_req = 1'b1;
                        OP_ARM:    ct_d.state   = ST_ARMED;
                        OP_IDREAD: begin
                            id_start   = 1'b1;
                            ct_d.state = ST_ID_WR;
                        end
                        default: ;
                    endcase
                end
            end
            ST_ARMED: begin
                if (win_hit) begin
                    ct_d.state = ST_IDLE;
                    if (win_zero) begin
                        ct_d.ld_req   = 1'b1;
                        ct_d.ld_block = cur_block;
                        ct_d.ld_page  = cur_page;
                        ct_d.state    = ST_WAIT_ACK;
                    end
                end
            end
            ST_WAIT_ACK: begin
                if (ld_ack) begin
                    ct_d.page_upd = 1'b1;
                    ct_d.page_val = DW'(page_next);
                    ct_d.state    = ST_IDLE;
                end
            end
            ST_ID_WR: begin
                if (id_last) begin
                    ct_d.state = ST_IDLE;
                end
            end
            default: ct_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_q <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign ld_req       = ct_q.ld_req;
    assign ld_block     = ct_q.ld_block;
    assign ld_page      = ct_q.ld_page;
    assign page_upd     = ct_q.page_upd;
    assign page_upd_val = ct_q.page_val;
    assign core_rst_req = ct_q.rst_req;

    // R4: the load request lasts one cycle
    a_r4_ld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> !ld_req);

    // R2: the reset request lasts one cycle
    a_r2_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_req |=> !core_rst_req);

    // R5: a page update only follows an acknowledge
    a_r5_upd_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        page_upd |-> $past(ld_ack));

    // R3: an accepted window write always leaves the armed state
    a_r3_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.state == ST_ARMED && win_hit) |=> ct_q.state != ST_ARMED);

    // R9: no new command is issued while busy
    a_r9_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.state == ST_WAIT_ACK || ct_q.state == ST_ID_WR) |=> (!core_rst_req && !ld_req));

endmodule

// File: tb/tb_bootcmd_ctrl.sv
module tb_bootcmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] cur_block = '0;
    logic [15:0] cur_page = '0;
    logic [15:0] mfr_id = 16'h12EC;
    logic [15:0] dev_id = 16'h0040;
    logic [15:0] wp_stat = 16'h0002;
    logic        ld_req;
    logic [15:0] ld_block;
    logic [15:0] ld_page;
    logic        ld_ack = 1'b0;
    logic        page_upd;
    logic [15:0] page_upd_val;
    logic        buf_we;
    logic [1:0]  buf_idx;
    logic [15:0] buf_wdata;
    logic        core_rst_req;

    int checks = 0;
    int errors = 0;
    int n_rst = 0, n_ld = 0, n_pw = 0, n_bw = 0;
    logic [15:0] last_blk, last_pg, last_pw;
    logic [15:0] bufmem [3];
    int ack_dly = 3;
    int ack_cnt = 0;

    always #5 clk = ~clk;

    bootcmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cur_block(cur_block), .cur_page(cur_page),
        .mfr_id(mfr_id), .dev_id(dev_id), .wp_stat(wp_stat),
        .ld_req(ld_req), .ld_block(ld_block), .ld_page(ld_page), .ld_ack(ld_ack),
        .page_upd(page_upd), .page_upd_val(page_upd_val),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
        .core_rst_req(core_rst_req)
    );

    // Monitor and loader stub
    always @(posedge clk) begin
        if (core_rst_req) n_rst <= n_rst + 1;
        if (ld_req) begin
            n_ld     <= n_ld + 1;
            last_blk <= ld_block;
            last_pg  <= ld_page;
        end
        if (page_upd) begin
            n_pw    <= n_pw + 1;
            last_pw <= page_upd_val;
        end
        if (buf_we) begin
            n_bw <= n_bw + 1;
            bufmem[buf_idx] <= buf_wdata;
        end
        if (ld_req) ack_cnt <= ack_dly;
        else if (ack_cnt > 0) ack_cnt <= ack_cnt - 1;
        ld_ack <= (ack_cnt == 1);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R10 ld_req after reset", int'(ld_req), 0);
        chk("R10 rst_req after reset", int'(core_rst_req), 0);
        chk("R10 buf_we after reset", int'(buf_we), 0);
        chk("R10 page_upd after reset", int'(page_upd), 0);
    endtask

    task automatic t_reset_cmd();
        int b = n_rst;
        wr(16'h0000, 16'h00F0);
        chk("R2 rst_req pulse high", int'(core_rst_req), 1);
        idle(1);
        chk("R2 rst_req one cycle", int'(core_rst_req), 0);
        wr(16'h800F, 16'h00F0);
        idle(2);
        chk("R2 rst count", n_rst - b, 2);
    endtask

    task automatic t_window();
        int b = n_rst;
        wr(16'h0200, 16'h00F0);
        wr(16'h7FFF, 16'h00F0);
        wr(16'h8010, 16'h00F0);
        wr(16'hF220, 16'h00F0);
        idle(2);
        chk("R1 outside window ignored", n_rst - b, 0);
        wr(16'h01FF, 16'h00F0);
        idle(2);
        chk("R1 window edge 0x01FF decoded", n_rst - b, 1);
    endtask

    task automatic t_load(input logic [15:0] blk, input logic [15:0] pg,
                          input logic [15:0] exp_pg);
        int bl = n_ld;
        int bp = n_pw;
        cur_block = blk; cur_page = pg;
        wr(16'h0000, 16'h00E0);
        wr(16'h0010, 16'h0000);
        cur_block = 16'hDEAD; cur_page = 16'hBEEF;
        idle(ack_dly + 4);
        chk("R4 one load", n_ld - bl, 1);
        chk("R4 load block", int'(last_blk), int'(blk));
        chk("R4 load page", int'(last_pg), int'(pg));
        chk("R5 one page update", n_pw - bp, 1);
        chk("R5 page update value", int'(last_pw), int'(exp_pg));
    endtask

    task automatic t_disarm();
        int bl = n_ld;
        int br = n_rst;
        wr(16'h0000, 16'h00E0);
        wr(16'h0004, 16'h0005);
        wr(16'h0000, 16'h0000);
        idle(6);
        chk("R6 nonzero second write no load", n_ld - bl, 0);
        wr(16'h0000, 16'h00E0);
        wr(16'h0000, 16'h00F0);
        wr(16'h0000, 16'h0000);
        idle(6);
        chk("R6 armed 0x00F0 gives no reset", n_rst - br, 0);
        chk("R3 disarmed after second write", n_ld - bl, 0);
    endtask

    task automatic t_arm_across();
        int bl = n_ld;
        wr(16'h01FF, 16'h00E0);
        wr(16'h8010, 16'h0000);
        idle(3);
        chk("R1 outside write keeps arm and loads nothing", n_ld - bl, 0);
        wr(16'h8000, 16'h0000);
        idle(ack_dly + 4);
        chk("R3 armed state survives outside write", n_ld - bl, 1);
    endtask

    task automatic t_id();
        int bw = n_bw;
        wr(16'h0100, 16'h0090);
        mfr_id = 16'h0000; dev_id = 16'h0000; wp_stat = 16'h0000;
        idle(5);
        chk("R7 three buffer writes", n_bw - bw, 3);
        chk("R7 word0 manufacturer", int'(bufmem[0]), 16'h00EC);
        chk("R7 word1 device", int'(bufmem[1]), 16'h0040);
        chk("R7 word2 protection", int'(bufmem[2]), 16'h0002);
        mfr_id = 16'h12EC; dev_id = 16'h0040; wp_stat = 16'h0002;
    endtask

    task automatic t_other();
        int bl = n_ld;
        int br = n_rst;
        int bw = n_bw;
        wr(16'h0000, 16'h1234);
        wr(16'h0000, 16'h00E1);
        wr(16'h0000, 16'h0000);
        idle(6);
        chk("R8 other codes no reset", n_rst - br, 0);
        chk("R8 other codes no load or arm", n_ld - bl, 0);
        chk("R8 other codes no buffer write", n_bw - bw, 0);
    endtask

    task automatic t_busy();
        int bl = n_ld;
        int br = n_rst;
        int bw = n_bw;
        ack_dly = 12;
        wr(16'h0000, 16'h00E0);
        wr(16'h0000, 16'h0000);
        wr(16'h0000, 16'h00F0);
        wr(16'h0000, 16'h00E0);
        idle(16);
        wr(16'h0000, 16'h0000);
        idle(6);
        chk("R9 one load only", n_ld - bl, 1);
        chk("R9 reset ignored while loading", n_rst - br, 0);
        ack_dly = 3;
        wr(16'h0000, 16'h0090);
        wr(16'h0000, 16'h00F0);
        idle(6);
        chk("R9 reset ignored during id write", n_rst - br, 0);
        chk("R9 id writes complete", n_bw - bw, 3);
    endtask

    task automatic t_rst_clears_arm();
        int bl = n_ld;
        wr(16'h0000, 16'h00E0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        wr(16'h0000, 16'h0000);
        idle(6);
        chk("R10 reset clears armed state", n_ld - bl, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset_state();
        t_reset_cmd();
        t_window();
        t_load(16'h0123, 16'h0014, 16'h0018);
        t_load(16'h8001, 16'h00FC, 16'h0000);
        t_load(16'h0007, 16'h01FE, 16'h0002);
        t_disarm();
        t_arm_across();
        t_id();
        t_other();
        t_busy();
        t_rst_clears_arm();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule